// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block keeps the pointer to the top of a stack that grows toward lower addresses. On each clock it may serve one stack operation: a single data byte pushed or popped, or a two-byte return address saved on a call or interrupt entry, or restored on a return. For each operation it computes the memory address or addresses of the access in the same cycle, and it computes the pointer value the access leaves behind. The memory itself and instruction sequencing stay outside. The operation requests are plain one-cycle strobes with no handshake, because the pointer always accepts an operation in the cycle it is requested.

Software sees the pointer as two byte-wide registers on a small I/O bus. One register holds the low eight bits and the other holds the remaining upper bits. Software can read either register at any time, and must load both before it relies on calls or interrupts, because the pointer resets to zero. The pointer width is a parameter from 9 to 16 bits. Upper register bits beyond the width read as zero and are dropped on write.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted and after reset is released, the pointer is zero. Both I/O registers then read as zero.
- R2: A data push places its byte at the current pointer (address 0) and lowers the pointer by one. acc_two_o stays 0.
- R3: A data pop reads its byte at pointer+1 (address 0) and raises the pointer by one.
- R4: A call saves two bytes and lowers the pointer by two. The low byte goes to the current pointer (address 0), the high byte goes to pointer-1 (address 1), and acc_two_o is 1.
- R5: A return restores two bytes and raises the pointer by two. The high byte is read from pointer+1 (address 0), the low byte from pointer+2 (address 1), and acc_two_o is 1.
- R6: When several strobes are high together, only one is served, with priority call, then return, then push, then pop.
- R7: An I/O write to address 0x3D replaces pointer bits 7:0. An I/O write to address 0x3E replaces bits SP_W-1:8 with the low SP_W-8 data bits. The other part of the pointer is kept.
- R8: An I/O write to either pointer register in the same cycle as a stack strobe wins. The stack operation is dropped, and acc_valid_o is 0 in that cycle.
- R9: io_rdata_o shows the low byte at 0x3D and the zero-extended upper bits at 0x3E. At any other address it shows zero, and writes to any other address leave the pointer unchanged.
- R10: Pointer arithmetic wraps modulo 2^SP_W in both directions.
- R11: sp_next_o always equals the value sp_o takes at the next clock edge. With no strobe and no pointer write, this is the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Data byte push strobe |
| pop_i | input | 1 | Data byte pop strobe |
| call_i | input | 1 | Return address save strobe (call or interrupt entry) |
| ret_i | input | 1 | Return address restore strobe |
| io_we_i | input | 1 | I/O write enable |
| io_addr_i | input | IO_AW | I/O register address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for io_addr_i |
| acc_valid_o | output | 1 | A stack access is being served this cycle |
| acc_two_o | output | 1 | The access covers two bytes |
| acc_addr0_o | output | SP_W | Address of the first byte accessed |
| acc_addr1_o | output | SP_W | Address of the second byte (valid when acc_two_o) |
| sp_o | output | SP_W | Current pointer |
| sp_next_o | output | SP_W | Pointer after this cycle |

## Verification
The bench builds the unit with SP_W set to 12, so the upper register holds only four live bits. This lets the bench check that extra high bits are dropped on write and read back as zero. It also makes wrap-around at 0xFFF and at zero easy to reach with short push and pop runs. The I/O addresses keep their defaults, and random writes also hit unrelated addresses to confirm they are ignored.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } sp_op_e;
endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
  import sp_pkg::*;
(
  input  logic   push_i,
  input  logic   pop_i,
  input  logic   call_i,
  input  logic   ret_i,
  output sp_op_e op_o
);
  // fixed priority: return-address traffic first, then data bytes
  always_comb begin
    if (call_i)      op_o = OP_CALL;
    else if (ret_i)  op_o = OP_RET;
    else if (push_i) op_o = OP_PUSH;
    else if (pop_i)  op_o = OP_POP;
    else             op_o = OP_NONE;
  end
endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
  import sp_pkg::*;
#(
  parameter int SP_W = 16
) (
  input  sp_op_e          op_i,
  input  logic [SP_W-1:0] sp_i,
  output logic            busy_o,
  output logic            two_o,
  output logic [SP_W-1:0] addr0_o,
  output logic [SP_W-1:0] addr1_o,
  output logic [SP_W-1:0] next_o
);
  localparam logic [SP_W-1:0] STEP1 = SP_W'(1);
  localparam logic [SP_W-1:0] STEP2 = SP_W'(2);

  logic [SP_W-1:0] sp_up1, sp_up2, sp_dn1, sp_dn2;

  assign sp_up1 = sp_i + STEP1;
  assign sp_up2 = sp_i + STEP2;
  assign sp_dn1 = sp_i - STEP1;
  assign sp_dn2 = sp_i - STEP2;

  always_comb begin
    busy_o  = 1'b1;
    two_o   = 1'b0;
    addr0_o = sp_i;
    addr1_o = sp_i;
    next_o  = sp_i;
    unique case (op_i)
      OP_PUSH: begin
        next_o = sp_dn1;
      end
      OP_POP: begin
        addr0_o = sp_up1;
        addr1_o = sp_up1;
        next_o  = sp_up1;
      end
      OP_CALL: begin
        two_o   = 1'b1;
        addr1_o = sp_dn1;
        next_o  = sp_dn2;
      end
      OP_RET: begin
        two_o   = 1'b1;
        addr0_o = sp_up1;
        addr1_o = sp_up2;
        next_o  = sp_up2;
      end
      default: begin
        busy_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sp_io_regs.sv
module sp_io_regs #(
  parameter int          SP_W    = 16,
  parameter int          IO_AW   = 6,
  parameter logic [IO_AW-1:0] LO_ADDR = IO_AW'(6'h3D),
  parameter logic [IO_AW-1:0] HI_ADDR = IO_AW'(6'h3E)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [7:0]       io_wdata_i,
  input  logic             stk_upd_i,
  input  logic [SP_W-1:0]  stk_next_i,
  output logic             io_hit_o,
  output logic [7:0]       io_rdata_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [SP_W-1:0]  sp_d_o
);
  localparam int HW = SP_W - 8;

  logic hit_lo, hit_hi;
  logic [SP_W-1:0] sp_q;

  assign hit_lo   = io_we_i && (io_addr_i == LO_ADDR);
  assign hit_hi   = io_we_i && (io_addr_i == HI_ADDR);
  assign io_hit_o = hit_lo || hit_hi;

  always_comb begin
    sp_d_o = sp_q;
    if (hit_lo)         sp_d_o[7:0]      = io_wdata_i;
    else if (hit_hi)    sp_d_o[SP_W-1:8] = io_wdata_i[HW-1:0];
    else if (stk_upd_i) sp_d_o           = stk_next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d_o;
  end

  always_comb begin
    if (io_addr_i == LO_ADDR)      io_rdata_o = sp_q[7:0];
    else if (io_addr_i == HI_ADDR) io_rdata_o = 8'(sp_q[SP_W-1:8]);
    else                           io_rdata_o = 8'h00;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int               SP_W    = 16,
  parameter int               IO_AW   = 6,
  parameter logic [IO_AW-1:0] LO_ADDR = IO_AW'(6'h3D),
  parameter logic [IO_AW-1:0] HI_ADDR = IO_AW'(6'h3E)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  output logic             acc_valid_o,
  output logic             acc_two_o,
  output logic [SP_W-1:0]  acc_addr0_o,
  output logic [SP_W-1:0]  acc_addr1_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [SP_W-1:0]  sp_next_o
);
  sp_op_e          op;
  logic            busy, two, io_hit;
  logic [SP_W-1:0] a0, a1, nxt, sp_cur;

  sp_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .op_o   (op)
  );

  sp_addr_gen #(.SP_W(SP_W)) u_agen (
    .op_i    (op),
    .sp_i    (sp_cur),
    .busy_o  (busy),
    .two_o   (two),
    .addr0_o (a0),
    .addr1_o (a1),
    .next_o  (nxt)
  );

  sp_io_regs #(
    .SP_W(SP_W), .IO_AW(IO_AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_we_i    (io_we_i),
    .io_addr_i  (io_addr_i),
    .io_wdata_i (io_wdata_i),
    .stk_upd_i  (busy),
    .stk_next_i (nxt),
    .io_hit_o   (io_hit),
    .io_rdata_o (io_rdata_o),
    .sp_o       (sp_cur),
    .sp_d_o     (sp_next_o)
  );

  // a software pointer write cancels the stack access of that cycle
  assign acc_valid_o = busy && !io_hit;
  assign acc_two_o   = two && !io_hit;
  assign acc_addr0_o = a0;
  assign acc_addr1_o = a1;
  assign sp_o        = sp_cur;
endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
  parameter int               SP_W    = 16,
  parameter int               IO_AW   = 6,
  parameter logic [IO_AW-1:0] LO_ADDR = IO_AW'(6'h3D),
  parameter logic [IO_AW-1:0] HI_ADDR = IO_AW'(6'h3E)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             pop_i,
  input logic             call_i,
  input logic             ret_i,
  input logic             io_we_i,
  input logic [IO_AW-1:0] io_addr_i,
  input logic             acc_valid_o,
  input logic             acc_two_o,
  input logic [SP_W-1:0]  sp_o,
  input logic [SP_W-1:0]  sp_next_o
);
  logic wr_lo, wr_hi;
  assign wr_lo = io_we_i && (io_addr_i == LO_ADDR);
  assign wr_hi = io_we_i && (io_addr_i == HI_ADDR);

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !call_i && !ret_i && !wr_lo && !wr_hi)
      |=> sp_o == SP_W'($past(sp_o) - SP_W'(1)));

  // R4
  call_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !wr_lo && !wr_hi) |=> sp_o == SP_W'($past(sp_o) - SP_W'(2)));

  // R5
  ret_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !wr_lo && !wr_hi) |=> sp_o == SP_W'($past(sp_o) + SP_W'(2)));

  // R8
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |-> !acc_valid_o && !acc_two_o);

  // R7
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> sp_o[SP_W-1:8] == $past(sp_o[SP_W-1:8]));

  // R11
  next_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sp_o == $past(sp_next_o));
endmodule

bind stack_ptr_unit sp_unit_chk #(
  .SP_W(SP_W), .IO_AW(IO_AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .io_we_i     (io_we_i),
  .io_addr_i   (io_addr_i),
  .acc_valid_o (acc_valid_o),
  .acc_two_o   (acc_two_o),
  .sp_o        (sp_o),
  .sp_next_o   (sp_next_o)
);

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 0, pop = 0, call = 0, ret = 0, we = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic vld, two;
  logic [W-1:0] a0, a1, sp, spn;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [W-1:0] sp_m = '0;

  always #5 clk = ~clk;

  stack_ptr_unit #(.SP_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .call_i(call), .ret_i(ret),
    .io_we_i(we), .io_addr_i(addr), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .acc_valid_o(vld), .acc_two_o(two), .acc_addr0_o(a0), .acc_addr1_o(a1),
    .sp_o(sp), .sp_next_o(spn)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, expv);
    end
  endtask

  // 0 none, 1 push, 2 pop, 3 call, 4 ret (R6 priority)
  function automatic int op_of(logic p, logic po, logic c, logic r);
    if (c) return 3;
    if (r) return 4;
    if (p) return 1;
    if (po) return 2;
    return 0;
  endfunction

  function automatic logic [W-1:0] exp_next(logic [W-1:0] s, int op, logic w,
                                            logic [5:0] a, logic [7:0] d);
    logic [W-1:0] n;
    n = s;
    if (w && a == 6'h3D)      n[7:0] = d;
    else if (w && a == 6'h3E) n[W-1:8] = d[W-9:0];
    else case (op)
      1: n = s - 1'b1;
      2: n = s + 1'b1;
      3: n = s - 2'd2;
      4: n = s + 2'd2;
      default: n = s;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] exp_rd(logic [W-1:0] s, logic [5:0] a);
    if (a == 6'h3D) return s[7:0];
    if (a == 6'h3E) return 8'(s[W-1:8]);
    return 8'h00;
  endfunction

  task automatic step(input logic p, input logic po, input logic c, input logic r,
                      input logic w, input logic [5:0] a, input logic [7:0] d);
    int op;
    bit hit;
    string tag;
    logic [W-1:0] en;
    @(negedge clk);
    push = p; pop = po; call = c; ret = r; we = w; addr = a; wdata = d;
    #1;
    op  = op_of(p, po, c, r);
    hit = w && (a == 6'h3D || a == 6'h3E);
    en  = exp_next(sp_m, op, w, a, d);
    if (hit) tag = "R8";
    else if ((int'(p) + int'(po) + int'(c) + int'(r)) > 1) tag = "R6";
    else case (op)
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = "R5";
      default: tag = "R11";
    endcase
    check(vld == (op != 0 && !hit), tag, int'(vld), int'(op != 0 && !hit));
    check(spn == en, {tag, "/R11"}, int'(spn), int'(en));
    check(rdata == exp_rd(sp_m, a), "R9", int'(rdata), int'(exp_rd(sp_m, a)));
    if (!hit && op != 0) begin
      case (op)
        1: check(a0 == sp_m && !two, tag, int'(a0), int'(sp_m));
        2: check(a0 == W'(sp_m + 1'b1) && !two, tag, int'(a0), int'(W'(sp_m + 1'b1)));
        3: begin
          check(a0 == sp_m && two, tag, int'(a0), int'(sp_m));
          check(a1 == W'(sp_m - 1'b1), tag, int'(a1), int'(W'(sp_m - 1'b1)));
        end
        default: begin
          check(a0 == W'(sp_m + 1'b1) && two, tag, int'(a0), int'(W'(sp_m + 1'b1)));
          check(a1 == W'(sp_m + 2'd2), tag, int'(a1), int'(W'(sp_m + 2'd2)));
        end
      endcase
    end
    @(posedge clk);
    #1;
    sp_m = en;
    if (w && !hit) tag = "R9";
    else if (w) tag = "R7";
    check(sp == sp_m, tag, int'(sp), int'(sp_m));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds pointer at zero
    check(sp == '0, "R1", int'(sp), 0);
    addr = 6'h3E;
    #1;
    check(rdata == 8'h00, "R1", int'(rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(sp == '0, "R1", int'(sp), 0);

    // R10: push below zero wraps to the top
    step(1, 0, 0, 0, 0, 6'h00, 8'h00);
    check(sp == 12'hFFF, "R10", int'(sp), 12'hFFF);
    step(0, 1, 0, 0, 0, 6'h00, 8'h00);
    check(sp == 12'h000, "R10", int'(sp), 0);
    step(0, 0, 0, 1, 0, 6'h00, 8'h00);
    check(sp == 12'h002, "R5", int'(sp), 2);
    step(0, 0, 1, 0, 0, 6'h00, 8'h00);
    step(0, 0, 1, 0, 0, 6'h00, 8'h00);
    check(sp == 12'hFFE, "R10", int'(sp), 12'hFFE);

    // R7: byte loads, extra high bits dropped
    step(0, 0, 0, 0, 1, 6'h3D, 8'h34);
    step(0, 0, 0, 0, 1, 6'h3E, 8'hAB);
    check(sp == 12'hB34, "R7", int'(sp), 12'hB34);
    step(0, 0, 0, 0, 0, 6'h3E, 8'h00);
    check(rdata == 8'h0B, "R9", int'(rdata), 8'h0B);

    // R6: all strobes together act as call
    step(1, 1, 1, 1, 0, 6'h00, 8'h00);
    check(sp == 12'hB32, "R6", int'(sp), 12'hB32);
    step(1, 1, 0, 1, 0, 6'h00, 8'h00);
    step(1, 1, 0, 0, 0, 6'h00, 8'h00);
    // R8: write cancels simultaneous push
    step(1, 0, 0, 0, 1, 6'h3D, 8'h77);
    check(sp == 12'hB77, "R8", int'(sp), 12'hB77);
    step(0, 0, 1, 0, 1, 6'h3E, 8'h01);
    // R9: write elsewhere ignored
    step(0, 0, 0, 0, 1, 6'h3C, 8'hFF);
    check(sp == 12'h177, "R9", int'(sp), 12'h177);

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] ra;
      int sel;
      sel = int'($urandom_range(0, 3));
      ra = (sel == 0) ? 6'h3D : (sel == 1) ? 6'h3E : 6'($urandom);
      step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0),
           1'($urandom_range(0, 6) == 0), ra, 8'($urandom));
    end
    summary();
  end
endmodule